// File: doc/BRIEF.md
# Port Power-State Controller

This block decides, cycle by cycle, whether one port of a synchronous dual-port memory is selected, whether that port may drive its tri-state data bus, and whether the port has broken the rules for entering or leaving sleep. The port is enabled only when its active-low enable is low and its active-high enable is high. A single disabled cycle powers the port down. The output driver comes back only after two enabled clock edges in a row.

A raw, asynchronous, active-high sleep request blanks the output driver at once. A synchronized copy of that request puts the port to sleep. While the port is asleep it stays deselected, it ignores its inputs, and it drops a clock-enable that freezes the port's internal registers. The port must stay disabled for three cycles before sleep takes effect and for three cycles after sleep ends. The first access after that exit window must be a read. Any break of these rules produces a one-cycle violation pulse.

Top module: `port_power_ctrl`

## Requirements
- R1: One clock cycle with `ce_n_i` high or `ce_i` low powers the port down. `drv_en_o` is 0 in that cycle and in the cycle that follows it.
- R2: `drv_en_o` is 1 only after two consecutive rising edges at which the port was enabled (`ce_n_i`=0, `ce_i`=1), and only while the port is still enabled and awake.
- R3: `drv_en_o` is 0 whenever `wr_i`=1 (1 = write, 0 = read).
- R4: When the synchronized sleep request takes effect, fewer than three disabled edges before that point, or an enabled port at that edge, produces a violation.
- R5: An enabled edge in any of the three edges that follow the synchronized sleep release produces a violation.
- R6: After the exit window closes, the first enabled edge produces a violation if `wr_i`=1. Later enabled edges produce no violation.
- R7: While asleep, `clk_en_o`=0 and `sel_o`=0. Enables and `wr_i` are ignored and raise no violation. Sleep takes effect two edges after `sleep_i` rises and ends two edges after it falls.
- R8: `sleep_i`=1 forces `drv_en_o` to 0 combinationally, without waiting for a clock edge.
- R9: While `rst_ni` is low, and after it is released, `drv_en_o`=0, `viol_o`=0 and `clk_en_o`=1, with all counters cleared.
- R10: `viol_o` is registered. It is 1 for exactly the one cycle after the offending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Enable, active low |
| ce_i | input | 1 | Enable, active high |
| wr_i | input | 1 | Access type, 1 = write, 0 = read |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| sel_o | output | 1 | Internal port select |
| drv_en_o | output | 1 | Data bus output-drive enable |
| viol_o | output | 1 | Sleep-protocol violation pulse |
| clk_en_o | output | 1 | Clock enable for the port's internal registers |

## Verification
The bench builds the block with its default parameters: a two-edge reactivation, a three-edge guard window and a two-stage synchronizer. With these values every sleep entry and exit completes in a handful of cycles, so a single vector walk can cover a clean sleep cycle followed by a faulty one. That walk reaches each violation source (too short an idle run before entry, access inside the exit window, a write as the first access) and also shows that a second write after the window raises nothing.

// File: rtl/port_power_pkg.sv
package port_power_pkg;
  typedef struct packed {
    logic pre_bad;
    logic post_bad;
    logic first_bad;
  } viol_src_t;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_i,
  output logic [STAGES-1:0] stg_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign stg_o = stg_q;
endmodule

// File: rtl/pp_sat_cnt.sv
module pp_sat_cnt #(
  parameter int MAX = 3,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         sat_o
);
  localparam logic [W-1:0] LIM = W'(MAX);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign sat_o = (cnt_q == LIM);
endmodule

// File: rtl/pp_guard.sv
module pp_guard
  import port_power_pkg::*;
#(
  parameter int GUARD_CYC = 3,
  localparam int GW = $clog2(GUARD_CYC + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      slp_cur_i,  // synchronized sleep, current
  input  logic      slp_nxt_i,  // value slp_cur_i takes at next edge
  input  logic      en_i,
  input  logic      wr_i,
  input  logic      idle_ok_i,
  output viol_src_t src_o
);
  localparam logic [GW-1:0] LAST = GW'(GUARD_CYC - 1);

  logic          post_act_q, first_pend_q;
  logic [GW-1:0] post_cnt_q;
  logic          enter, leave;

  assign enter = slp_nxt_i & ~slp_cur_i;
  assign leave = slp_cur_i & ~slp_nxt_i;

  assign src_o.pre_bad   = enter & (en_i | ~idle_ok_i);
  assign src_o.post_bad  = post_act_q & en_i;
  assign src_o.first_bad = first_pend_q & ~post_act_q & ~slp_cur_i & en_i & wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_act_q   <= 1'b0;
      post_cnt_q   <= '0;
      first_pend_q <= 1'b0;
    end else if (leave) begin
      post_act_q   <= 1'b1;
      post_cnt_q   <= '0;
      first_pend_q <= 1'b0;
    end else if (post_act_q) begin
      post_cnt_q <= post_cnt_q + 1'b1;
      if (post_cnt_q == LAST) begin
        post_act_q   <= 1'b0;
        first_pend_q <= 1'b1;
      end
    end else if (enter || (first_pend_q && en_i)) begin
      first_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/port_power_ctrl.sv
module port_power_ctrl
  import port_power_pkg::*;
#(
  parameter int ACT_CYC     = 2,
  parameter int GUARD_CYC   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  input  logic ce_i,
  input  logic wr_i,
  input  logic sleep_i,
  output logic sel_o,
  output logic drv_en_o,
  output logic viol_o,
  output logic clk_en_o
);
  localparam int AW = $clog2(ACT_CYC + 1);
  localparam int IW = $clog2(GUARD_CYC + 1);

  logic [SYNC_STAGES-1:0] slp_stg;
  logic                   slp_cur, slp_nxt, en_raw;
  logic [AW-1:0]          act_cnt;
  logic [IW-1:0]          idle_cnt;
  logic                   act_ok, idle_ok, viol_q;
  viol_src_t              src;

  assign en_raw  = ~ce_n_i & ce_i;
  assign slp_cur = slp_stg[SYNC_STAGES-1];
  assign slp_nxt = slp_stg[SYNC_STAGES-2];

  pp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sleep_i),
    .stg_o  (slp_stg)
  );

  // consecutive enabled edges, cleared by any disabled or sleeping edge
  pp_sat_cnt #(.MAX(ACT_CYC)) u_act (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~en_raw | slp_cur),
    .inc_i  (1'b1),
    .cnt_o  (act_cnt),
    .sat_o  (act_ok)
  );

  // consecutive disabled edges, frozen while asleep
  pp_sat_cnt #(.MAX(GUARD_CYC)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (en_raw & ~slp_cur),
    .inc_i  (~slp_cur),
    .cnt_o  (idle_cnt),
    .sat_o  (idle_ok)
  );

  pp_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slp_cur_i (slp_cur),
    .slp_nxt_i (slp_nxt),
    .en_i      (en_raw),
    .wr_i      (wr_i),
    .idle_ok_i (idle_ok),
    .src_o     (src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= |src;
  end

  assign sel_o    = en_raw & ~slp_cur & ~sleep_i;
  assign drv_en_o = act_ok & en_raw & ~wr_i & ~slp_cur & ~sleep_i;
  assign viol_o   = viol_q;
  assign clk_en_o = ~slp_cur;

  logic unused_cnt;
  assign unused_cnt = ^{act_cnt, idle_cnt};
endmodule

// File: rtl/port_power_chk.sv
module port_power_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_n_i,
  input logic ce_i,
  input logic wr_i,
  input logic sleep_i,
  input logic sel_o,
  input logic drv_en_o,
  input logic clk_en_o
);
  assert_drop_after_disable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_n_i || !ce_i) |=> !drv_en_o);

  assert_drive_needs_prior_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> $past(!ce_n_i && ce_i));

  assert_no_drive_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !drv_en_o);

  assert_asleep_deselected_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> !sel_o);

  assert_raw_sleep_blanks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !drv_en_o);
endmodule

bind port_power_ctrl port_power_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_n_i   (ce_n_i),
  .ce_i     (ce_i),
  .wr_i     (wr_i),
  .sleep_i  (sleep_i),
  .sel_o    (sel_o),
  .drv_en_o (drv_en_o),
  .clk_en_o (clk_en_o)
);

// File: tb/port_power_ctrl_test.sv
module port_power_ctrl_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce_n = 1'b1, ce = 1'b0, wr = 1'b0, slp = 1'b0;
  logic sel, drv, viol, cken;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  port_power_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_n_i(ce_n), .ce_i(ce), .wr_i(wr),
    .sleep_i(slp), .sel_o(sel), .drv_en_o(drv), .viol_o(viol), .clk_en_o(cken)
  );

  // {ce_n ce wr sleep}, {sel drv viol clk_en}, requirement
  localparam int NV = 41;
  localparam logic [11:0] VEC [NV] = '{
    {4'b1000, 4'b0001, 4'd9},   // R9 idle after reset
    {4'b0100, 4'b1001, 4'd2},   // R2
    {4'b0100, 4'b1001, 4'd2},
    {4'b0100, 4'b1101, 4'd2},
    {4'b0110, 4'b1001, 4'd3},   // R3 write
    {4'b1100, 4'b0001, 4'd1},   // R1 ce_n high
    {4'b0100, 4'b1001, 4'd2},
    {4'b0000, 4'b0001, 4'd1},   // R1 ce low
    {4'b0100, 4'b1001, 4'd2},
    {4'b0100, 4'b1001, 4'd2},
    {4'b0100, 4'b1101, 4'd2},
    {4'b1000, 4'b0001, 4'd1},
    {4'b1000, 4'b0001, 4'd4},   // R4 idle run
    {4'b1000, 4'b0001, 4'd4},
    {4'b1001, 4'b0001, 4'd8},
    {4'b1001, 4'b0001, 4'd4},
    {4'b0111, 4'b0000, 4'd7},   // R7 toggles ignored
    {4'b1001, 4'b0000, 4'd7},
    {4'b1000, 4'b0000, 4'd7},
    {4'b1000, 4'b0000, 4'd7},
    {4'b1000, 4'b0001, 4'd5},   // R5 clean window
    {4'b1000, 4'b0001, 4'd5},
    {4'b1000, 4'b0001, 4'd5},
    {4'b0100, 4'b1001, 4'd6},   // R6 first access read
    {4'b0100, 4'b1001, 4'd6},
    {4'b0100, 4'b1101, 4'd2},
    {4'b1000, 4'b0001, 4'd1},
    {4'b0100, 4'b1001, 4'd2},
    {4'b1001, 4'b0001, 4'd4},   // R4 short idle run
    {4'b1001, 4'b0001, 4'd4},
    {4'b1001, 4'b0010, 4'd4},
    {4'b1001, 4'b0000, 4'd10},  // R10 single cycle
    {4'b1000, 4'b0000, 4'd7},
    {4'b1000, 4'b0000, 4'd7},
    {4'b0100, 4'b1001, 4'd5},   // R5 access in window
    {4'b1000, 4'b0011, 4'd5},
    {4'b1000, 4'b0001, 4'd10},
    {4'b0110, 4'b1001, 4'd6},   // R6 write first
    {4'b1000, 4'b0011, 4'd6},
    {4'b0110, 4'b1001, 4'd10},
    {4'b1000, 4'b0001, 4'd6}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input logic [3:0] e);
    chk(req, "sel_o",    sel,  e[3]);
    chk(req, "drv_en_o", drv,  e[2]);
    chk(req, "viol_o",   viol, e[1]);
    chk(req, "clk_en_o", cken, e[0]);
  endtask

  task automatic drive(input logic [3:0] v);
    {ce_n, ce, wr, slp} = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_vec("R9", 4'b0001);  // in reset
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][11:8]);
      #1;
      chk_vec($sformatf("R%0d", VEC[i][3:0]), VEC[i][7:4]);
    end
    // R8: raw sleep blanks the driver between edges
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      drive(4'b0100);
    end
    #1 chk("R8", "drv_en_o before sleep", drv, 1'b1);
    slp = 1'b1;
    #1 chk("R8", "drv_en_o on raw sleep", drv, 1'b0);
    // R9: reset mid-run with port enabled
    @(negedge clk);
    rst_ni = 1'b0;
    drive(4'b0100);
    #1 chk_vec("R9", 4'b1001);
    @(negedge clk);
    rst_ni = 1'b1;
    #1 chk("R9", "drv_en_o after release", drv, 1'b0);
    @(negedge clk);
    #1 chk("R9", "drv_en_o one edge", drv, 1'b0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule